// File: doc/BRIEF.md
# Single-Wire Time-Delay Sensor Reader

This block is the host-side master of one open-drain wire that is shared by up to eight time-delay sensors. When asked to measure, it pulls the wire low for a fixed trigger time and then lets go. An external pull-up returns the idle wire to the high level. Each sensor later answers by pulling the wire low. The time from the release to that answer holds the sensor's reading. The block counts clock cycles from the release, takes the count when the answering falling edge arrives, and splits the count into a device slot and an offset inside that slot.

The wire is never driven high. The only control the block has is an output-enable, and while that enable is asserted the pad pulls the wire low. The wire level comes back on an input that is asynchronous to the clock, so it passes through a two-stage synchronizer first. If no device answers within the timeout count, the block flags a timeout. After a report or a timeout the block goes idle with the wire released, and it waits there for the next start request. The trigger length, slot length, slot count and timeout are parameters in clock cycles. The trigger length must be at least 3 cycles so that the synchronizer has settled low before the release.

Top module: `swire_delay_reader`

## Requirements
- R1: While reset is high, and after it, `line_oe_o`, `valid_o` and `timeout_o` are 0, and `result_o` and `slot_o` are 0.
- R2: If `start_i` is 1 at a clock edge while the block is idle, `line_oe_o` goes to 1 after that edge and stays 1 for exactly `TRIG_CYC` cycles. It then returns to 0, and that edge is the release edge E0.
- R3: `start_i` has no effect from the trigger until the report or timeout edge. It neither restarts nor stretches the trigger or the measurement.
- R4: Let E0+k be the first edge after the release at which the wire is sampled low, where the edge before it sampled the wire high. The measured delay D is then k+1 cycles. `valid_o` is 1 for exactly the one cycle after edge E0+k+2.
- R5: Only a high-to-low transition of the sampled wire counts as an answer. A wire that is still held low at the release does not produce a report, the rise that follows the release does not, and any edge after the first answer does not.
- R6: On a report, `slot_o` = min(D / `WIN_CYC`, `SLOTS`-1) and `result_o` = D - `slot_o`*`WIN_CYC`. The last slot is open-ended.
- R7: `result_o` and `slot_o` change only in the cycle `valid_o` is 1. They keep their values through a timeout.
- R8: If no answer is reported, `timeout_o` is 1 for the one cycle after edge E0+`TMO_CYC`. An answer that reports on that same edge wins, and no timeout is flagged.
- R9: After a report or a timeout the block is idle with `line_oe_o` at 0. No new trigger begins until `start_i` is 1 again.
- R10: `valid_o` and `timeout_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Measurement request, sampled while idle |
| line_i | input | 1 | Wire level, asynchronous, high when nothing pulls it low |
| line_oe_o | output | 1 | Pull the wire low while 1; never drives high |
| result_o | output | CNT_W | Delay offset inside the answering slot |
| slot_o | output | SLOT_W | Index of the slot holding the answer |
| valid_o | output | 1 | One-cycle strobe: new result and slot |
| timeout_o | output | 1 | One-cycle strobe: no answer before the timeout |

## Verification
The reference model tracks each phase of the block by itself. A sequencer stuck in the wrong phase therefore shows up on `line_oe_o` or on a missing strobe on the first edge where the two disagree. A counter that is off by one shows up as a wrong `result_o` or `slot_o` in the cycle `valid_o` rises, or as a timeout one edge early or late. The chosen answer delays land on slot boundaries and on both sides of the timeout edge, so an error in the comparator chain or in the priority between answer and timeout appears in the very report it corrupts.

// File: rtl/swdr_pkg.sv
package swdr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TRIG = 2'd1,
    PH_MEAS = 2'd2
  } swdr_phase_e;
endpackage

// File: rtl/swdr_line_sync.sv
module swdr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  // Reset to the idle (pulled-up) level so no false edge follows reset.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b1;
        else     chain_q[g] <= line_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b1;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b1;
    else     hist_q <= chain_q[STAGES-1];
  end

  assign fall_o = hist_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/swdr_seq_ctrl.sv
module swdr_seq_ctrl
  import swdr_pkg::*;
#(
  parameter int TRIG_CYC = 50,
  parameter int TMO_CYC  = 524288,
  parameter int CNT_W    = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             fall_i,
  output logic             oe_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             capture_o,
  output logic             valid_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] TRIG_LAST = CNT_W'(TRIG_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_CYC - 1);

  swdr_phase_e      phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign capture_o = (phase_q == PH_MEAS) && fall_i;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      oe_o      <= 1'b0;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_TRIG;
            oe_o    <= 1'b1;
            cnt_q   <= '0;
          end
        end
        PH_TRIG: begin
          if (cnt_q == TRIG_LAST) begin
            phase_q <= PH_MEAS;
            oe_o    <= 1'b0;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_MEAS: begin
          // An answer on the last counted cycle takes priority over timeout.
          if (fall_i) begin
            valid_o <= 1'b1;
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else if (cnt_q == TMO_LAST) begin
            timeout_o <= 1'b1;
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          oe_o    <= 1'b0;
          cnt_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/swdr_slot_split.sv
module swdr_slot_split #(
  parameter int WIN_CYC = 500,
  parameter int SLOTS   = 8,
  parameter int CNT_W   = 19,
  parameter int SLOT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  result_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [31:0]       cnt_ext;
  logic [SLOTS-1:1]  past_edge;
  logic [SLOT_W-1:0] slot_c;
  logic [31:0]       base_c;

  assign cnt_ext = 32'(cnt_i);

  // One comparator per slot boundary; the passed boundaries form a thermometer code.
  for (genvar k = 1; k < SLOTS; k++) begin : g_edge
    assign past_edge[k] = (cnt_ext >= 32'(k * WIN_CYC));
  end

  always_comb begin
    slot_c = '0;
    base_c = '0;
    for (int k = 1; k < SLOTS; k++) begin
      if (past_edge[k]) begin
        slot_c = SLOT_W'(k);
        base_c = 32'(k * WIN_CYC);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      slot_o   <= '0;
    end else if (capture_i) begin
      result_o <= CNT_W'(cnt_ext - base_c);
      slot_o   <= slot_c;
    end
  end
endmodule

// File: rtl/swire_delay_reader.sv
module swire_delay_reader #(
  parameter int TRIG_CYC    = 50,
  parameter int WIN_CYC     = 500,
  parameter int SLOTS       = 8,
  parameter int TMO_CYC     = 524288,
  parameter int SYNC_STAGES = 2,
  localparam int MAX_CYC    = (TMO_CYC > TRIG_CYC) ? TMO_CYC : TRIG_CYC,
  localparam int CNT_W      = $clog2(MAX_CYC),
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              line_i,
  output logic              line_oe_o,
  output logic [CNT_W-1:0]  result_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o,
  output logic              timeout_o
);
  logic             fall_w;
  logic             capture_w;
  logic [CNT_W-1:0] cnt_w;

  swdr_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .line_i(line_i),
    .fall_o(fall_w)
  );

  swdr_seq_ctrl #(
    .TRIG_CYC(TRIG_CYC),
    .TMO_CYC (TMO_CYC),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .fall_i   (fall_w),
    .oe_o     (line_oe_o),
    .cnt_o    (cnt_w),
    .capture_o(capture_w),
    .valid_o  (valid_o),
    .timeout_o(timeout_o)
  );

  swdr_slot_split #(
    .WIN_CYC(WIN_CYC),
    .SLOTS  (SLOTS),
    .CNT_W  (CNT_W),
    .SLOT_W (SLOT_W)
  ) u_split (
    .clk      (clk),
    .rst      (rst),
    .capture_i(capture_w),
    .cnt_i    (cnt_w),
    .result_o (result_o),
    .slot_o   (slot_o)
  );
endmodule

// File: rtl/swire_delay_reader_chk.sv
module swire_delay_reader_chk #(
  parameter int TRIG_CYC = 50,
  parameter int WIN_CYC  = 500,
  parameter int SLOTS    = 8,
  parameter int CNT_W    = 19,
  parameter int SLOT_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              line_oe_o,
  input logic [CNT_W-1:0]  result_o,
  input logic [SLOT_W-1:0] slot_o,
  input logic              valid_o,
  input logic              timeout_o
);
  int unsigned oe_run;

  always_ff @(posedge clk) begin
    if (rst)            oe_run <= 0;
    else if (line_oe_o) oe_run <= oe_run + 1;
    else                oe_run <= 0;
  end

  // R2
  oe_len_chk: assert property (@(posedge clk) disable iff (rst)
    oe_run <= 32'(TRIG_CYC));

  // R2
  oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(line_oe_o) |-> $past(start_i));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o || timeout_o) |-> !line_oe_o);

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && timeout_o));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(result_o) && $stable(slot_o)));

  // R6
  range_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((32'(result_o) < 32'(WIN_CYC)) || (32'(slot_o) == 32'(SLOTS - 1))));
endmodule

bind swire_delay_reader swire_delay_reader_chk #(
  .TRIG_CYC(TRIG_CYC),
  .WIN_CYC (WIN_CYC),
  .SLOTS   (SLOTS),
  .CNT_W   (CNT_W),
  .SLOT_W  (SLOT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .line_oe_o(line_oe_o),
  .result_o (result_o),
  .slot_o   (slot_o),
  .valid_o  (valid_o),
  .timeout_o(timeout_o)
);

// File: tb/swire_delay_reader_tb_top.sv
module swire_delay_reader_tb_top;
  localparam int TRIG  = 6;
  localparam int WIN   = 40;
  localparam int NSLOT = 8;
  localparam int TMO   = 400;
  localparam int CW    = $clog2(TMO);
  localparam int SW    = $clog2(NSLOT);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_r = 1'b0;
  logic pull_r = 1'b0;
  logic line_w, oe_w, valid_w, tmo_w;
  logic [CW-1:0] res_w;
  logic [SW-1:0] slot_w;

  always #2 clk = ~clk;

  // Open-drain wire with pull-up: low when either end pulls it.
  assign line_w = !(oe_w || pull_r);

  swire_delay_reader #(
    .TRIG_CYC(TRIG), .WIN_CYC(WIN), .SLOTS(NSLOT), .TMO_CYC(TMO), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_r), .line_i(line_w),
    .line_oe_o(oe_w), .result_o(res_w), .slot_o(slot_w),
    .valid_o(valid_w), .timeout_o(tmo_w)
  );

  int checks = 0;
  int errors = 0;

  // Reference model state: 0 idle, 1 trigger, 2 measuring
  int m_ph = 0, m_t = 0, m_n = 0, m_pend = -1, m_dly = 0, m_res = 0, m_slot = 0;
  bit m_last = 1'b1, m_oe = 1'b0, m_val = 1'b0, m_tmo = 1'b0;

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_edge(input bit st, input bit ln, input bit rs);
    m_val = 1'b0;
    m_tmo = 1'b0;
    if (rs) begin
      m_ph = 0; m_res = 0; m_slot = 0; m_last = 1'b1;
    end else begin
      case (m_ph)
        0: if (st) begin m_ph = 1; m_t = 0; end
        1: begin
          m_t++;
          if (m_t == TRIG) begin m_ph = 2; m_n = 0; m_pend = -1; end
        end
        default: begin
          m_n++;
          if (m_pend < 0 && m_last && !ln) begin m_pend = m_n + 2; m_dly = m_n + 1; end
          if (m_pend == m_n) begin
            m_val  = 1'b1;
            m_ph   = 0;
            m_slot = (m_dly / WIN > NSLOT - 1) ? NSLOT - 1 : m_dly / WIN;
            m_res  = m_dly - m_slot * WIN;
          end else if (m_n == TMO) begin
            m_tmo = 1'b1;
            m_ph  = 0;
          end
        end
      endcase
      m_last = ln;
    end
    m_oe = (m_ph == 1);
  endtask

  task automatic step();
    bit st, ln, rs;
    st = start_r;
    ln = !(m_oe || pull_r);
    rs = rst;
    @(negedge clk);
    model_edge(st, ln, rs);
    expect_eq("R2 R3 R9 line_oe_o", int'(oe_w), int'(m_oe));
    expect_eq("R4 valid_o", int'(valid_w), int'(m_val));
    expect_eq("R8 timeout_o", int'(tmo_w), int'(m_tmo));
    expect_eq("R6 R7 result_o", int'(res_w), m_res);
    expect_eq("R6 R7 slot_o", int'(slot_w), m_slot);
    expect_eq("R10 strobe overlap", int'(valid_w && tmo_w), 0);
  endtask

  int last_res = 0, last_slot = 0;

  task automatic measure(input int k, input bit answer);
    int nv, nt, d, sl;
    nv = 0; nt = 0;
    start_r = 1'b1;
    step();
    start_r = 1'b0;
    while (!(m_ph == 2 && m_n == k - 1)) step();
    if (answer) pull_r = 1'b1;
    do begin
      step();
      nv += int'(valid_w);
      nt += int'(tmo_w);
    end while (m_ph != 0);
    repeat (3) step();
    pull_r = 1'b0;
    repeat (3) step();
    if (answer && k + 2 <= TMO) begin
      d  = k + 1;
      sl = (d / WIN > NSLOT - 1) ? NSLOT - 1 : d / WIN;
      expect_eq("R4 one report", nv, 1);
      expect_eq("R6 slot", int'(slot_w), sl);
      expect_eq("R6 offset", int'(res_w), d - sl * WIN);
      expect_eq("R8 no timeout when answered", nt, 0);
      last_res = d - sl * WIN;
      last_slot = sl;
    end else begin
      expect_eq("R8 one timeout", nt, 1);
      expect_eq("R8 no report", nv, 0);
      expect_eq("R7 result kept", int'(res_w), last_res);
      expect_eq("R7 slot kept", int'(slot_w), last_slot);
    end
  endtask

  initial begin
    repeat (4) step();
    // R1: reset values
    expect_eq("R1 line_oe_o", int'(oe_w), 0);
    expect_eq("R1 valid_o", int'(valid_w), 0);
    expect_eq("R1 timeout_o", int'(tmo_w), 0);
    expect_eq("R1 result_o", int'(res_w), 0);
    expect_eq("R1 slot_o", int'(slot_w), 0);
    rst = 1'b0;
    repeat (3) step();

    measure(10, 1'b1);   // slot 0
    measure(38, 1'b1);   // delay 39: last cycle of slot 0
    measure(39, 1'b1);   // delay 40: first cycle of slot 1
    measure(300, 1'b1);  // slot 7
    measure(350, 1'b1);  // beyond slot 7 start: open-ended last slot
    measure(398, 1'b1);  // R8: report on the timeout edge wins
    measure(399, 1'b1);  // R8: too late, timeout
    measure(5, 1'b0);    // R8: silent wire

    // R3: start held high for the whole measurement
    start_r = 1'b1;
    step();
    while (!(m_ph == 2 && m_n == 29)) step();
    pull_r = 1'b1;
    do step(); while (m_ph != 0);
    start_r = 1'b0;
    expect_eq("R3 offset with start held", int'(res_w), 31);
    repeat (3) step();
    pull_r = 1'b0;
    // R9: stays idle without a new request
    repeat (20) step();
    expect_eq("R9 wire released when idle", int'(oe_w), 0);

    // R5: sensor holds the wire low across release, lets go, then answers
    start_r = 1'b1;
    step();
    start_r = 1'b0;
    pull_r = 1'b1;
    while (!(m_ph == 2 && m_n == 19)) step();
    pull_r = 1'b0;
    while (!(m_ph == 2 && m_n == 59)) step();
    expect_eq("R5 no report from held-low wire", int'(valid_w), 0);
    pull_r = 1'b1;
    do step(); while (m_ph != 0);
    expect_eq("R5 answer after re-fall slot", int'(slot_w), 1);
    expect_eq("R5 answer after re-fall offset", int'(res_w), 21);
    // R5: a second fall after the report is not another answer
    pull_r = 1'b0;
    repeat (3) step();
    pull_r = 1'b1;
    repeat (6) step();
    expect_eq("R5 later fall ignored", int'(res_w), 21);
    pull_r = 1'b0;
    repeat (4) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule